// File: doc/BRIEF.md
# Word-Serial SHA-256 Compression Unit

This block runs the SHA-256 compression function on message blocks that have already been padded, one 512-bit block at a time. It can also run a chain of such blocks. Message words enter 32 bits per cycle. All arithmetic passes through one 32-bit adder. A small sequencer steps each round through a fixed series of micro-steps, and that adder forms every partial sum in turn. The design spends clock cycles to save area.

Three flip-flop register files hold the working data:

- a 16-word window for the message schedule, reused in a circular way;
- eight working variables;
- eight chaining words.

The round constants come from a constant table that is indexed by the round counter, so no memory macro is needed.

To use the block:

1. Pulse `init` to load the standard initial hash value.
2. Pulse `start`, then present the sixteen words of the block on `din` with `din_valid`.
3. Wait for `done`.
4. Read the digest one word at a time through `rd_idx`.

To hash a longer message, run further blocks without pulsing `init`. Each result is then added on top of the previous chaining value.

Top module: `sha256_serial_core`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are both low.
- R2: A pulse on `init` while idle loads the chaining file with the standard SHA-256 initial hash words. Reading `rd_idx` = k returns word k, where index 0 is the most significant digest word (6a09e667 after init).
- R3: A `start` pulse while idle raises `busy` at the next clock edge. The block then accepts exactly sixteen words, one on each cycle where `din_valid` is high. The first accepted word is the most significant word of the block. Cycles with `din_valid` low are skipped.
- R4: After one block, the chaining file holds the SHA-256 compression of the previous chaining value and the block. For the padded message "abc" after init, the digest reads ba7816bf … f20015ad.
- R5: Blocks run without an `init` in between are chained: each block starts from the digest left by the block before it. For the standard 56-byte two-block vector, the digest reads 248d6a61 … 19db06c1.
- R6: `done` is high for exactly one cycle. It rises at the 601st clock edge after the edge that accepts the sixteenth word. `busy` falls on that same edge.
- R7: While `busy` is high, `start`, `init` and `din_valid` have no effect, and the chaining file changes only during the final add-back cycles. While idle, `din_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Load the initial hash value into the chaining file (idle only) |
| start | input | 1 | Begin a block (idle only) |
| din_valid | input | 1 | `din` carries a message word this cycle |
| din | input | 32 | Message word, most significant word first |
| rd_idx | input | 3 | Digest word select, 0 = most significant |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle completion pulse |
| dout | output | 32 | Chaining word selected by `rd_idx` (combinational) |

## Verification
`busy` is due one edge after `start`, so the bench samples it at the falling edge that follows the start edge. `done` is due 601 edges after the edge that takes the last message word. The bench counts falling edges from that point and expects `done` at count 601 exactly, then low with `busy` low one edge later. The digest is read combinationally during the `done` cycle, between the falling edge and the next rising edge. The ignored-input checks apply their stimulus in mid-round and then compare the whole digest of that block against the bench's own reference compression.

// File: rtl/sha256_pkg.sv
`timescale 1ns/1ps
package sha256_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned SCHED_N  = 16;
    localparam int unsigned STATE_N  = 8;
    localparam int unsigned ROUNDS   = 64;
    localparam int unsigned SCHED_AW = $clog2(SCHED_N);
    localparam int unsigned STATE_AW = $clog2(STATE_N);
    localparam int unsigned RND_AW   = $clog2(ROUNDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [STATE_N-1:0] oct_t;
    typedef word_t [SCHED_N-1:0] win_t;

    typedef enum logic [2:0] {PH_IDLE, PH_LOAD, PH_COPY, PH_RND, PH_FIN, PH_DONE} phase_e;

    // micro-steps of one round; schedule steps are skipped for rounds below SCHED_N
    typedef enum logic [3:0] {
        SP_WA, SP_WB, SP_WC,          // schedule word: three additions
        SP_HS, SP_CH, SP_KC, SP_WT,   // first temporary: four additions
        SP_T2,                        // second temporary
        SP_NE, SP_NA                  // new e, new a plus shift
    } step_e;

    localparam oct_t IV_WORDS = {
        32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
        32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667};

    localparam word_t RC_TAB [ROUNDS] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

    function automatic word_t rotr(input word_t x, input int unsigned n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction
    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction
    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction
    function automatic word_t small_sig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction
    function automatic word_t small_sig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction
    function automatic word_t f_choose(input word_t e, input word_t f, input word_t g);
        return (e & f) ^ (~e & g);
    endfunction
    function automatic word_t f_major(input word_t a, input word_t b, input word_t c);
        return (a & b) ^ (a & c) ^ (b & c);
    endfunction
    function automatic word_t round_const(input logic [RND_AW-1:0] idx);
        return RC_TAB[idx];
    endfunction
endpackage

// File: rtl/sha256_sched_rf.sv
`timescale 1ns/1ps
module sha256_sched_rf import sha256_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [SCHED_AW-1:0] widx,
    input  word_t               wdata,
    output win_t                q
);
    for (genvar g = 0; g < SCHED_N; g++) begin : g_ent
        logic ent_en;
        assign ent_en = we && (widx == SCHED_AW'(g));
        always_ff @(posedge clk) begin
            if (rst)         q[g] <= '0;
            else if (ent_en) q[g] <= wdata;
        end
    end
endmodule

// File: rtl/sha256_state_rf.sv
`timescale 1ns/1ps
module sha256_state_rf import sha256_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  load_en,
    input  oct_t  load_val,
    input  logic  shift_en,
    input  word_t new_a,
    input  word_t new_e,
    output oct_t  q
);
    // entry 0 is a, entry 4 is e, entry 7 is h
    for (genvar g = 0; g < STATE_N; g++) begin : g_ent
        word_t shift_in;
        if (g == 0) begin : g_a
            assign shift_in = new_a;
        end else if (g == STATE_N / 2) begin : g_e
            assign shift_in = new_e;
        end else begin : g_mid
            assign shift_in = q[g-1];
        end
        always_ff @(posedge clk) begin
            if (rst)           q[g] <= '0;
            else if (load_en)  q[g] <= load_val[g];
            else if (shift_en) q[g] <= shift_in;
        end
    end
endmodule

// File: rtl/sha256_chain_rf.sv
`timescale 1ns/1ps
module sha256_chain_rf import sha256_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic                init_en,
    input  logic                we,
    input  logic [STATE_AW-1:0] widx,
    input  word_t               wdata,
    output oct_t                q
);
    for (genvar g = 0; g < STATE_N; g++) begin : g_ent
        logic ent_en;
        assign ent_en = we && (widx == STATE_AW'(g));
        always_ff @(posedge clk) begin
            if (rst)          q[g] <= '0;
            else if (init_en) q[g] <= IV_WORDS[g];
            else if (ent_en)  q[g] <= wdata;
        end
    end
endmodule

// File: rtl/sha256_serial_core.sv
`timescale 1ns/1ps
module sha256_serial_core import sha256_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic                init,
    input  logic                start,
    input  logic                din_valid,
    input  logic [WORD_W-1:0]   din,
    input  logic [STATE_AW-1:0] rd_idx,
    output logic                busy,
    output logic                done,
    output logic [WORD_W-1:0]   dout
);
    phase_e              phase;
    step_e               step;
    logic [RND_AW-1:0]   cnt;
    word_t               acc, t1, ne;
    win_t                w_q;
    oct_t                st_q, chain_q;
    logic [SCHED_AW-1:0] j, jm2, jm7, jp1;
    word_t               opa, opb, sum;
    logic                sched_we, st_load, st_shift, ch_init, ch_we, fin_phase;

    assign j   = cnt[SCHED_AW-1:0];
    assign jm2 = j - SCHED_AW'(2);
    assign jm7 = j - SCHED_AW'(7);
    assign jp1 = j + SCHED_AW'(1);

    // operand selection for the single shared adder
    always_comb begin
        opa = '0;
        opb = '0;
        if (phase == PH_FIN) begin
            opa = chain_q[cnt[STATE_AW-1:0]];
            opb = st_q[cnt[STATE_AW-1:0]];
        end else begin
            case (step)
                SP_WA: begin opa = small_sig1(w_q[jm2]); opb = w_q[jm7]; end
                SP_WB: begin opa = acc; opb = small_sig0(w_q[jp1]); end
                SP_WC: begin opa = acc; opb = w_q[j]; end
                SP_HS: begin opa = st_q[7]; opb = big_sig1(st_q[4]); end
                SP_CH: begin opa = acc; opb = f_choose(st_q[4], st_q[5], st_q[6]); end
                SP_KC: begin opa = acc; opb = round_const(cnt); end
                SP_WT: begin opa = acc; opb = w_q[j]; end
                SP_T2: begin opa = big_sig0(st_q[0]); opb = f_major(st_q[0], st_q[1], st_q[2]); end
                SP_NE: begin opa = st_q[3]; opb = t1; end
                SP_NA: begin opa = t1; opb = acc; end
                default: begin opa = '0; opb = '0; end
            endcase
        end
    end
    assign sum = opa + opb;

    assign sched_we  = (phase == PH_LOAD && din_valid) || (phase == PH_RND && step == SP_WC);
    assign st_load   = (phase == PH_COPY);
    assign st_shift  = (phase == PH_RND) && (step == SP_NA);
    assign ch_init   = (phase == PH_IDLE) && init;
    assign fin_phase = (phase == PH_FIN);
    assign ch_we     = fin_phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= SP_HS;
            cnt   <= '0;
            acc   <= '0;
            t1    <= '0;
            ne    <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_LOAD;
                    cnt   <= '0;
                end
                PH_LOAD: if (din_valid) begin
                    if (cnt == RND_AW'(SCHED_N - 1)) begin
                        phase <= PH_COPY;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + RND_AW'(1);
                    end
                end
                PH_COPY: begin
                    phase <= PH_RND;
                    step  <= SP_HS;
                end
                PH_RND: begin
                    if (step != SP_NE && step != SP_NA) acc <= sum;
                    if (step == SP_WT) t1 <= sum;
                    if (step == SP_NE) ne <= sum;
                    if (step == SP_NA) begin
                        step <= (cnt >= RND_AW'(SCHED_N - 1)) ? SP_WA : SP_HS;
                        if (cnt == RND_AW'(ROUNDS - 1)) begin
                            phase <= PH_FIN;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + RND_AW'(1);
                        end
                    end else begin
                        step <= step_e'(step + 4'd1);
                    end
                end
                PH_FIN: begin
                    if (cnt == RND_AW'(STATE_N - 1)) begin
                        phase <= PH_DONE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + RND_AW'(1);
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    sha256_sched_rf u_sched (
        .clk(clk), .rst(rst), .we(sched_we), .widx(j),
        .wdata((phase == PH_LOAD) ? din : sum), .q(w_q));

    sha256_state_rf u_state (
        .clk(clk), .rst(rst), .load_en(st_load), .load_val(chain_q),
        .shift_en(st_shift), .new_a(sum), .new_e(ne), .q(st_q));

    sha256_chain_rf u_chain (
        .clk(clk), .rst(rst), .init_en(ch_init), .we(ch_we),
        .widx(cnt[STATE_AW-1:0]), .wdata(sum), .q(chain_q));

    assign busy = (phase == PH_LOAD) || (phase == PH_COPY) || (phase == PH_RND) || fin_phase;
    assign done = (phase == PH_DONE);
    assign dout = chain_q[rd_idx];
endmodule

// File: rtl/sha256_serial_chk.sv
`timescale 1ns/1ps
module sha256_serial_chk import sha256_pkg::*; (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic fin_phase,
    input oct_t chain_q
);
    // R6: completion pulse lasts a single cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: busy is never high together with done
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6: busy only ever ends by way of the done pulse
    a_r6_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(busy)) |-> done);

    // R3: an accepted start raises busy on the next edge
    a_r3_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> busy);

    // R7: chaining file holds still while busy, except during add-back
    a_r7_chain_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !fin_phase) |=> $stable(chain_q));
endmodule

bind sha256_serial_core sha256_serial_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .fin_phase(fin_phase), .chain_q(chain_q));

// File: tb/sim_sha256_serial_core.sv
`timescale 1ns/1ps
module sim_sha256_serial_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init = 1'b0;
    logic        start = 1'b0;
    logic        din_valid = 1'b0;
    logic [31:0] din = '0;
    logic [2:0]  rd_idx = '0;
    logic        busy, done;
    logic [31:0] dout;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sha256_serial_core u0 (
        .clk(clk), .rst(rst), .init(init), .start(start), .din_valid(din_valid),
        .din(din), .rd_idx(rd_idx), .busy(busy), .done(done), .dout(dout));

    localparam logic [255:0] H_INIT =
        256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;

    localparam logic [31:0] BK [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    // reference compression: word 0 at the top of each vector
    function automatic logic [255:0] ref_compress(input logic [255:0] hin, input logic [511:0] blk);
        logic [31:0]  w [64];
        logic [31:0]  v [8];
        logic [31:0]  a1, a2;
        logic [255:0] r;
        for (int t = 0; t < 16; t++) w[t] = blk[511 - 32*t -: 32];
        for (int t = 16; t < 64; t++)
            w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
                 + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
        for (int i = 0; i < 8; i++) v[i] = hin[255 - 32*i -: 32];
        for (int t = 0; t < 64; t++) begin
            a1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
               + ((v[4] & v[5]) ^ (~v[4] & v[6])) + BK[t] + w[t];
            a2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + a1;
            v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = a1 + a2;
        end
        for (int i = 0; i < 8; i++) r[255 - 32*i -: 32] = hin[255 - 32*i -: 32] + v[i];
        return r;
    endfunction

    function automatic logic [511:0] rand_block();
        logic [511:0] b;
        for (int i = 0; i < 16; i++) b[511 - 32*i -: 32] = $urandom;
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_digest(output logic [255:0] dig);
        for (int k = 0; k < 8; k++) begin
            rd_idx = k[2:0];
            #0.5;
            dig[255 - 32*k -: 32] = dout;
        end
    endtask

    task automatic pulse_init();
        @(negedge clk) init = 1'b1;
        @(negedge clk) init = 1'b0;
    endtask

    // runs one block; gaps inserts idle cycles with junk on din, poke disturbs mid-round
    task automatic run_block(input logic [511:0] m, input bit gaps, input bit poke, output logic [255:0] dig);
        int lat;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy === 1'b1, "R3 busy after start", 256'(busy), 256'(1));
        for (int k = 0; k < 16; k++) begin
            while (gaps && ($urandom % 3 == 0)) begin
                din_valid = 1'b0;
                din = $urandom;
                @(negedge clk);
            end
            din = m[511 - 32*k -: 32];
            din_valid = 1'b1;
            @(negedge clk);
        end
        din_valid = 1'b0;
        lat = 0;
        while (lat < 2000) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 100) begin
                start = 1'b1; init = 1'b1; din_valid = 1'b1; din = $urandom;
            end
            if (poke && lat == 101) begin
                start = 1'b0; init = 1'b0; din_valid = 1'b0;
            end
            if (done === 1'b1) break;
        end
        check(lat == 601, "R6 done latency", 256'(lat), 256'(601));
        check(busy === 1'b0, "R6 busy low with done", 256'(busy), 256'(0));
        read_digest(dig);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R6 done single cycle", 256'({done, busy}), 256'(0));
    endtask

    localparam logic [511:0] ABC_BLK =
        {32'h61626380, {14{32'h0}}, 32'h00000018};
    localparam logic [255:0] ABC_DIG =
        256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    localparam logic [511:0] TWO_B1 =
        {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667, 32'h65666768, 32'h66676869,
         32'h6768696a, 32'h68696a6b, 32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
         32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
    localparam logic [511:0] TWO_B2 = {{15{32'h0}}, 32'h000001c0};
    localparam logic [255:0] TWO_DIG =
        256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;

    initial begin : watchdog
        #500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [255:0] dig, prev;
        logic [511:0] m;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy === 1'b0 && done === 1'b0, "R1 reset outputs", 256'({busy, done}), 256'(0));

        // R2: init loads the initial words, word 0 most significant
        pulse_init();
        read_digest(dig);
        check(dig === H_INIT, "R2 init value", dig, H_INIT);

        // R4: single-block known vector
        run_block(ABC_BLK, 1'b0, 1'b0, dig);
        check(dig === ABC_DIG, "R4 abc digest", dig, ABC_DIG);
        check(dig === ref_compress(H_INIT, ABC_BLK), "R4 abc vs model", dig, ref_compress(H_INIT, ABC_BLK));

        // R7: start/init/din_valid poked mid-round, chained on the abc result (R5)
        prev = dig;
        m = rand_block();
        run_block(m, 1'b0, 1'b1, dig);
        check(dig === ref_compress(prev, m), "R7 inputs ignored while busy", dig, ref_compress(prev, m));

        // R7: din_valid while idle has no effect; R5 two-block vector with gaps (R3)
        pulse_init();
        @(negedge clk) begin din_valid = 1'b1; din = 32'hdeadbeef; end
        repeat (3) @(negedge clk);
        din_valid = 1'b0;
        run_block(TWO_B1, 1'b1, 1'b0, dig);
        check(dig === ref_compress(H_INIT, TWO_B1), "R3 first block with gaps", dig, ref_compress(H_INIT, TWO_B1));
        run_block(TWO_B2, 1'b1, 1'b0, dig);
        check(dig === TWO_DIG, "R5 two-block digest", dig, TWO_DIG);

        // R5: random chained blocks
        pulse_init();
        prev = H_INIT;
        for (int b = 0; b < 3; b++) begin
            m = rand_block();
            run_block(m, b[0], 1'b0, dig);
            check(dig === ref_compress(prev, m), "R5 random chained block", dig, ref_compress(prev, m));
            prev = dig;
        end

        // R4: all-ones and all-zero corner blocks after init
        pulse_init();
        run_block({16{32'hffffffff}}, 1'b0, 1'b0, dig);
        check(dig === ref_compress(H_INIT, {16{32'hffffffff}}), "R4 all-ones block",
              dig, ref_compress(H_INIT, {16{32'hffffffff}}));
        pulse_init();
        run_block('0, 1'b1, 1'b0, dig);
        check(dig === ref_compress(H_INIT, '0), "R4 all-zero block", dig, ref_compress(H_INIT, '0));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule